// File: doc/BRIEF.md
# Script Instruction Prefetch Unit

This block sits between a script sequencer and a bus master. When prefetching is switched on, a sequencer fetch that misses the local buffer starts one read burst of consecutive 32-bit words, beginning at the missed address. The words land in an eight-entry buffer. Each entry has its own valid flag, so the sequencer can take the first word while the rest of the burst is still arriving. Later fetches that fall inside the buffered window are answered from the buffer, with no bus traffic.

The burst length is worked out from a two-bit length code. The code gives a permitted maximum, and the issued burst is that maximum capped at the buffer depth. If the permitted maximum is below four words, or prefetching is switched off, the unit acts as a pass-through: every fetch becomes a separate single-word read, and the word is not kept once it has been delivered. A jump from the sequencer forces a new burst at the target, even when the target is already buffered. If prefetching is switched off while a burst is in flight, that burst runs to completion and the buffer is discarded afterwards.

The sequencer holds its request, address and jump flag until `fetch_valid_o` is high. The bus side holds each request until it is granted, then expects exactly the requested number of read beats.

Top module: `script_prefetch`

## Requirements
- R1: After reset, `bus_req_o` and `fetch_valid_o` are both low.
- R2: With prefetch enabled, a missed fetch issues a burst whose length depends on the length code: code 1 gives 4 words, code 2 gives 8 words and code 3 gives 8 words, because the permitted 16 is capped at the 8-entry buffer.
- R3: With prefetch disabled, or with length code 0 (permitted 2 words), every fetch issues its own 1-word request. A repeated fetch of the same address issues a fresh request.
- R4: A fetch inside the current window whose entry is valid is answered in the same cycle as the request, and no bus request is made.
- R5: A fetch outside the window flushes the buffer and starts a burst whose `bus_addr_o` equals the fetch address.
- R6: A fetch with `jump_i` high starts a new burst at the fetch address, even when that address lies inside the current window.
- R7: On a miss, the requested word is delivered 3 cycles after the request is first presented, provided the grant comes in the cycle after `bus_req_o` rises. This happens before the rest of the burst has arrived.
- R8: Clearing the enable during a burst lets every beat of that burst be accepted. The buffered words are then discarded, so a following fetch of an address from that burst issues a new 1-word request.
- R9: `bus_req_o`, `bus_addr_o` and `bus_len_o` stay unchanged until `bus_gnt_i` is seen. Each cycle of grant delay adds one cycle to the miss latency.
- R10: Every word delivered on `fetch_data_o` equals the bus data read for the requested address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pf_en_i | input | 1 | Prefetch enable |
| burst_code_i | input | 2 | Length code; permitted maximum is 2 << code words |
| fetch_req_i | input | 1 | Sequencer fetch request, held until served |
| jump_i | input | 1 | Fetch follows a program counter write; forces a new burst |
| fetch_addr_i | input | AW (32) | Word address of the fetch |
| fetch_valid_o | output | 1 | Fetch is served this cycle |
| fetch_data_o | output | DW (32) | Instruction word |
| bus_req_o | output | 1 | Burst read request, held until granted |
| bus_gnt_i | input | 1 | Bus accepts the request |
| bus_addr_o | output | AW (32) | First word address of the burst |
| bus_len_o | output | LEN_W (4) | Burst length in words (1, 4 or 8) |
| bus_rvalid_i | input | 1 | Read beat valid |
| bus_rdata_i | input | DW (32) | Read beat data |

## Verification
A buffered hit is due in the same cycle its request is presented. A miss raises `bus_req_o` one cycle after the request. With an immediate grant, the word comes out three cycles after the request, and one further cycle for each cycle of grant delay. The driver counts clock edges from the moment it presents a request until the monitor samples a served fetch just before an edge, and it compares that count with the latency stated for the case. The bench's bus model records the address and length of each granted burst and the number of beats still owed, so the checks on burst sizing, flushing and absence of bus traffic are made at the bus ports once the relevant fetch has been served.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_DATA
  } pf_state_e;
endpackage

// File: rtl/pf_burst_sizer.sv
module pf_burst_sizer #(
  parameter int unsigned CODE_W    = 2,
  parameter int unsigned BUF_WORDS = 8,
  parameter int unsigned MIN_BURST = 4,
  parameter int unsigned LEN_W     = $clog2(BUF_WORDS + 1)
) (
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [LEN_W-1:0]  len_o,
  output logic              bypass_o
);
  int unsigned max_words;
  int unsigned issued;

  always_comb begin
    max_words = 32'd2 << code_i;
    issued    = (max_words > BUF_WORDS) ? BUF_WORDS : max_words;
    bypass_o  = !en_i || (max_words < MIN_BURST);
    len_o     = bypass_o ? LEN_W'(1) : LEN_W'(issued);
  end
endmodule

// File: rtl/pf_buffer.sv
module pf_buffer #(
  parameter int unsigned DW        = 32,
  parameter int unsigned BUF_WORDS = 8,
  parameter int unsigned IDX_W     = $clog2(BUF_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [DW-1:0]    rd_data_o,
  output logic             rd_vld_o
);
  logic [DW-1:0]        mem_q [BUF_WORDS];
  logic [BUF_WORDS-1:0] vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
    end else if (flush_i) begin
      vld_q <= '0;
    end else if (wr_i) begin
      vld_q[wr_idx_i] <= 1'b1;
    end
  end

  generate
    for (genvar g = 0; g < BUF_WORDS; g++) begin : g_ent
      always_ff @(posedge clk_i) begin
        if (wr_i && !flush_i && wr_idx_i == IDX_W'(g)) mem_q[g] <= wr_data_i;
      end
    end
  endgenerate

  assign rd_data_o = mem_q[rd_idx_i];
  assign rd_vld_o  = vld_q[rd_idx_i];
endmodule

// File: rtl/pf_ctrl.sv
module pf_ctrl
  import pf_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned BUF_WORDS = 8,
  parameter int unsigned LEN_W     = $clog2(BUF_WORDS + 1),
  parameter int unsigned IDX_W     = $clog2(BUF_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LEN_W-1:0] cfg_len_i,
  input  logic             cfg_bypass_i,
  input  logic             fetch_req_i,
  input  logic             jump_i,
  input  logic [AW-1:0]    fetch_addr_i,
  input  logic             ent_vld_i,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             hit_o,
  output logic             flush_o,
  output logic             wr_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic             bus_req_o,
  input  logic             bus_gnt_i,
  output logic [AW-1:0]    bus_addr_o,
  output logic [LEN_W-1:0] bus_len_o,
  input  logic             bus_rvalid_i
);
  pf_state_e        state_q;
  logic [AW-1:0]    base_q;
  logic [LEN_W-1:0] len_q;
  logic [IDX_W-1:0] cnt_q;
  logic             win_ok_q, bypass_q, jmp_taken_q;

  logic [AW-1:0] offset;
  logic          stale, in_win, jump_new, start, last_beat;

  always_comb begin
    offset    = fetch_addr_i - base_q;
    // prefetched window outlives a disable only until the burst ends
    stale     = (state_q == ST_IDLE) && !bypass_q && cfg_bypass_i;
    in_win    = win_ok_q && !stale && (offset < AW'(len_q));
    jump_new  = fetch_req_i && jump_i && !jmp_taken_q;
    hit_o     = fetch_req_i && in_win && !jump_new && ent_vld_i;
    start     = (state_q == ST_IDLE) && fetch_req_i && (jump_new || !in_win);
    last_beat = (state_q == ST_DATA) && bus_rvalid_i &&
                (cnt_q == IDX_W'(len_q - 1'b1));
  end

  assign rd_idx_o   = offset[IDX_W-1:0];
  assign flush_o    = start;
  assign wr_o       = (state_q == ST_DATA) && bus_rvalid_i;
  assign wr_idx_o   = cnt_q;
  assign bus_req_o  = (state_q == ST_REQ);
  assign bus_addr_o = base_q;
  assign bus_len_o  = len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      base_q      <= '0;
      len_q       <= LEN_W'(1);
      cnt_q       <= '0;
      win_ok_q    <= 1'b0;
      bypass_q    <= 1'b1;
      jmp_taken_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q  <= ST_REQ;
          base_q   <= fetch_addr_i;
          len_q    <= cfg_len_i;
          bypass_q <= cfg_bypass_i;
        end
        ST_REQ: if (bus_gnt_i) state_q <= ST_DATA;
        ST_DATA: if (bus_rvalid_i) begin
          cnt_q <= last_beat ? '0 : cnt_q + 1'b1;
          if (last_beat) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase

      if (start)                   win_ok_q <= 1'b1;
      else if (stale)              win_ok_q <= 1'b0;
      else if (hit_o && bypass_q)  win_ok_q <= 1'b0;

      if (start)      jmp_taken_q <= jump_i;
      else if (hit_o) jmp_taken_q <= 1'b0;
    end
  end
endmodule

// File: rtl/script_prefetch.sv
module script_prefetch #(
  parameter int unsigned AW        = 32,
  parameter int unsigned DW        = 32,
  parameter int unsigned CODE_W    = 2,
  parameter int unsigned BUF_WORDS = 8,
  parameter int unsigned MIN_BURST = 4,
  localparam int unsigned LEN_W    = $clog2(BUF_WORDS + 1),
  localparam int unsigned IDX_W    = $clog2(BUF_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pf_en_i,
  input  logic [CODE_W-1:0] burst_code_i,
  input  logic              fetch_req_i,
  input  logic              jump_i,
  input  logic [AW-1:0]     fetch_addr_i,
  output logic              fetch_valid_o,
  output logic [DW-1:0]     fetch_data_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [AW-1:0]     bus_addr_o,
  output logic [LEN_W-1:0]  bus_len_o,
  input  logic              bus_rvalid_i,
  input  logic [DW-1:0]     bus_rdata_i
);
  logic [LEN_W-1:0] cfg_len;
  logic             cfg_bypass, ent_vld, flush, wr;
  logic [IDX_W-1:0] rd_idx, wr_idx;

  pf_burst_sizer #(
    .CODE_W(CODE_W), .BUF_WORDS(BUF_WORDS), .MIN_BURST(MIN_BURST), .LEN_W(LEN_W)
  ) u_sizer (
    .en_i(pf_en_i), .code_i(burst_code_i), .len_o(cfg_len), .bypass_o(cfg_bypass)
  );

  pf_ctrl #(
    .AW(AW), .BUF_WORDS(BUF_WORDS), .LEN_W(LEN_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .cfg_len_i(cfg_len), .cfg_bypass_i(cfg_bypass),
    .fetch_req_i, .jump_i, .fetch_addr_i,
    .ent_vld_i(ent_vld), .rd_idx_o(rd_idx), .hit_o(fetch_valid_o),
    .flush_o(flush), .wr_o(wr), .wr_idx_o(wr_idx),
    .bus_req_o, .bus_gnt_i, .bus_addr_o, .bus_len_o, .bus_rvalid_i
  );

  pf_buffer #(
    .DW(DW), .BUF_WORDS(BUF_WORDS), .IDX_W(IDX_W)
  ) u_buf (
    .clk_i, .rst_ni,
    .flush_i(flush), .wr_i(wr), .wr_idx_i(wr_idx), .wr_data_i(bus_rdata_i),
    .rd_idx_i(rd_idx), .rd_data_o(fetch_data_o), .rd_vld_o(ent_vld)
  );
endmodule

// File: rtl/script_prefetch_checker.sv
module script_prefetch_checker #(
  parameter int unsigned AW     = 32,
  parameter int unsigned CODE_W = 2,
  parameter int unsigned LEN_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pf_en_i,
  input logic [CODE_W-1:0] burst_code_i,
  input logic              fetch_req_i,
  input logic              fetch_valid_o,
  input logic              bus_req_o,
  input logic              bus_gnt_i,
  input logic [AW-1:0]     bus_addr_o,
  input logic [LEN_W-1:0]  bus_len_o
);
  assert_req_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_gnt_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_len_o));

  assert_len_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> (bus_len_o == LEN_W'(1) || bus_len_o == LEN_W'(4) || bus_len_o == LEN_W'(8)));

  assert_off_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_req_o) && !$past(pf_en_i) |-> bus_len_o == LEN_W'(1));

  assert_code1_four_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_req_o) && $past(pf_en_i) && $past(burst_code_i) == CODE_W'(1)
      |-> bus_len_o == LEN_W'(4));

  assert_serve_needs_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_o |-> fetch_req_i);
endmodule

bind script_prefetch script_prefetch_checker #(
  .AW(AW), .CODE_W(CODE_W), .LEN_W(LEN_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pf_en_i(pf_en_i), .burst_code_i(burst_code_i),
  .fetch_req_i(fetch_req_i), .fetch_valid_o(fetch_valid_o),
  .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt_i),
  .bus_addr_o(bus_addr_o), .bus_len_o(bus_len_o)
);

// File: tb/script_prefetch_test.sv
`timescale 1ns/1ps
module script_prefetch_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pf_en = 1'b0;
  logic [1:0]  code = 2'd0;
  logic        freq = 1'b0, jmp = 1'b0;
  logic [31:0] faddr = '0;
  logic        fvalid;
  logic [31:0] fdata;
  logic        breq;
  logic        bgnt = 1'b0;
  logic [31:0] baddr;
  logic [3:0]  blen;
  logic        brvalid = 1'b0;
  logic [31:0] brdata = '0;

  always #4 clk = ~clk;

  script_prefetch uut (
    .clk_i(clk), .rst_ni(rst_n), .pf_en_i(pf_en), .burst_code_i(code),
    .fetch_req_i(freq), .jump_i(jmp), .fetch_addr_i(faddr),
    .fetch_valid_o(fvalid), .fetch_data_o(fdata),
    .bus_req_o(breq), .bus_gnt_i(bgnt), .bus_addr_o(baddr), .bus_len_o(blen),
    .bus_rvalid_i(brvalid), .bus_rdata_i(brdata)
  );

  int n_checks = 0, n_errs = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  bit served = 0;

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return 32'hC0DE_0000 ^ (a * 32'h9E37);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus memory model
  int gnt_delay = 0, wcnt = 0, beats_left = 0, n_bursts = 0;
  logic [31:0] a_l = '0, last_addr = '0;
  int len_l = 0, last_len = 0;
  initial forever begin
    @(negedge clk);
    brvalid = 1'b0;
    if (bgnt) begin
      bgnt = 1'b0;
      beats_left = len_l;
    end
    if (beats_left > 0) begin
      brvalid = 1'b1;
      brdata = mem_word(a_l);
      a_l++;
      beats_left--;
    end else if (breq && !bgnt) begin
      if (wcnt < gnt_delay) wcnt++;
      else begin
        wcnt = 0;
        bgnt = 1'b1;
        a_l = baddr;
        len_l = int'(blen);
        n_bursts++;
        last_addr = baddr;
        last_len = int'(blen);
      end
    end
  end

  // monitor: sample just before the rising edge
  initial forever begin
    @(negedge clk);
    #3;
    if (rst_n && freq && fvalid) begin
      if (exp_q.size() == 0) chk(0, "R10 unexpected word", fdata, 32'h0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(fdata == e, "R10 fetch data", fdata, e);
      end
      served = 1;
    end
  end

  task automatic fetch(input logic [31:0] a, input bit j, output int lat);
    @(negedge clk);
    freq = 1'b1; jmp = j; faddr = a; served = 0;
    exp_q.push_back(mem_word(a));
    lat = 0;
    forever begin
      @(posedge clk);
      if (served) break;
      lat++;
    end
  endtask

  task automatic idle(int n);
    @(negedge clk);
    freq = 1'b0; jmp = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    n_checks++; n_errs++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    int lat, nb;
    repeat (3) @(negedge clk);
    chk(breq == 1'b0, "R1 bus_req after reset", 32'(breq), 0);
    chk(fvalid == 1'b0, "R1 fetch_valid after reset", 32'(fvalid), 0);
    rst_n = 1'b1;
    pf_en = 1'b1; code = 2'd2;
    idle(2);

    // R7/R5/R2: miss starts burst of 8, first word early
    fetch(32'h100, 0, lat);
    chk(lat == 3, "R7 miss latency", lat, 3);
    chk(beats_left > 0, "R7 served before burst end", beats_left, 1);
    chk(last_addr == 32'h100, "R5 burst address", last_addr, 32'h100);
    chk(last_len == 8, "R2 code 2 length", last_len, 8);
    for (int i = 1; i < 8; i++) begin
      fetch(32'h100 + i, 0, lat);
      chk(lat == 0, "R4 hit same cycle", lat, 0);
    end
    chk(n_bursts == 1, "R4 no bus traffic on hits", n_bursts, 1);

    // R5: miss elsewhere
    fetch(32'h200, 0, lat);
    chk(last_addr == 32'h200 && n_bursts == 2, "R5 new burst on miss", last_addr, 32'h200);

    // R2: code 3 capped, code 1 four
    idle(12); code = 2'd3;
    fetch(32'h300, 0, lat);
    chk(last_len == 8, "R2 code 3 capped", last_len, 8);
    idle(12); code = 2'd1;
    fetch(32'h400, 0, lat);
    chk(last_len == 4, "R2 code 1 length", last_len, 4);
    fetch(32'h404, 0, lat);
    chk(last_addr == 32'h404 && last_len == 4, "R2 window of four ends", last_addr, 32'h404);

    // R6: jump inside window
    idle(10);
    nb = n_bursts;
    fetch(32'h406, 0, lat);
    chk(lat == 0 && n_bursts == nb, "R4 buffered hit", lat, 0);
    fetch(32'h405, 1, lat);
    chk(n_bursts == nb + 1 && last_addr == 32'h405, "R6 jump forces burst", last_addr, 32'h405);
    chk(lat == 3, "R6 jump latency", lat, 3);
    idle(2);
    fetch(32'h406, 0, lat);
    chk(lat == 0 && n_bursts == nb + 1, "R6 window at target", n_bursts, nb + 1);

    // R3: code 0 -> single words, not retained
    idle(10); code = 2'd0;
    nb = n_bursts;
    fetch(32'h500, 0, lat);
    chk(last_len == 1 && lat == 3, "R3 code 0 single word", last_len, 1);
    fetch(32'h500, 0, lat);
    chk(n_bursts == nb + 2, "R3 repeat fetch re-requested", n_bursts, nb + 2);
    fetch(32'h501, 0, lat);
    chk(last_len == 1 && last_addr == 32'h501, "R3 next word single", last_addr, 32'h501);

    // R3: disabled
    idle(4); pf_en = 1'b0; code = 2'd2;
    fetch(32'h600, 0, lat);
    chk(last_len == 1, "R3 disabled single word", last_len, 1);

    // R8: disable mid-burst
    idle(4); pf_en = 1'b1;
    fetch(32'h700, 0, lat);
    chk(last_len == 8, "R8 burst started", last_len, 8);
    idle(0); pf_en = 1'b0;
    nb = n_bursts;
    idle(12);
    chk(beats_left == 0 && n_bursts == nb, "R8 burst completed", beats_left, 0);
    fetch(32'h701, 0, lat);
    chk(n_bursts == nb + 1 && last_len == 1, "R8 buffer discarded", n_bursts, nb + 1);

    // R9: grant delay
    idle(4); pf_en = 1'b1; code = 2'd1; gnt_delay = 3;
    fetch(32'h800, 0, lat);
    chk(lat == 6, "R9 grant delay latency", lat, 6);
    chk(last_addr == 32'h800 && last_len == 4, "R9 request held", last_addr, 32'h800);
    gnt_delay = 0;

    idle(12);
    chk(exp_q.size() == 0, "R10 all words delivered", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule